// File: doc/BRIEF.md
# Line-Cycle Qualifier and Seconds Prescaler

This block turns a squared, possibly noisy power-line waveform into a one-second strobe. The raw line signal is brought into the system clock domain by a two-flop synchronizer. A falling-edge detector then drives a small ramp-timer state machine. Every falling edge, noise edges included, clears the ramp and starts it again. The state machine emits one qualified line-cycle pulse only when the ramp reaches its threshold before another falling edge arrives. An edge that comes too soon therefore cancels the pending count instead of adding one, so a noisy line can make the clock lose a count but never gain one.

Qualified pulses feed a two-stage divider. The first stage divides by ten. The second stage divides by six for a 60 Hz line or by five for a 50 Hz line, chosen by the build-time parameter `LINE_HZ`. The tick is a one-cycle strobe, registered one cycle after the qualified pulse on which both stages wrap.

The ramp state machine has three states:
- `RAMP_HOLD`: the timer is saturated and waiting. This is the reset state.
- `RAMP_RUN`: the timer is counting.
- `RAMP_FIRE`: the qualified pulse is high for one cycle.

Its transitions are:
- HOLD→RUN on a falling edge.
- RUN→RUN on a falling edge, with the count cleared.
- RUN→RUN with the count advanced when there is no edge and the count is below the last step.
- RUN→FIRE when there is no edge and the count equals `RAMP_CYCLES-1`.
- FIRE→RUN on a falling edge.
- FIRE→HOLD otherwise.

Top module: `mains_tick_gen`

## Requirements
- R1: Only falling edges of the synchronized line input act on the block; a rising edge or a steady high or low level never produces a qualified pulse.
- R2: A falling edge first sampled low at clock edge k yields, if uninterrupted, a qualified pulse high during the cycle after edge k+2+`RAMP_CYCLES` (two synchronizer stages, then `RAMP_CYCLES` ramp steps).
- R3: A falling edge is qualified only if the next falling edge comes more than `RAMP_CYCLES` clock cycles later; a gap of `RAMP_CYCLES` or fewer cycles restarts the ramp and produces no pulse.
- R4: Each qualified falling edge produces exactly one single-cycle pulse; with no further edge the timer holds saturated and does not re-fire.
- R5: Under any pattern of noise edges, the number of qualified pulses equals the number of falling edges followed by a gap longer than `RAMP_CYCLES`, so noise never adds a count.
- R6: With `LINE_HZ`=60, `tick_o` pulses once per 60 qualified pulses, exactly one cycle after every 60th.
- R7: With `LINE_HZ`=50, `tick_o` pulses once per 50 qualified pulses, exactly one cycle after every 50th.
- R8: Synchronous reset clears the synchronizer, the timer (held saturated in `RAMP_HOLD`), both divider stages and both outputs; no pulse occurs until a falling edge is seen after reset.
- R9: `tick_o` is one cycle wide and high only in the cycle right after a qualified pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Squared line waveform, asynchronous |
| qual_pulse_o | output | 1 | One-cycle qualified line-cycle pulse |
| tick_o | output | 1 | One-cycle strobe once per second |

## Verification
The bench targets the gap boundary where the spacing between falling edges equals `RAMP_CYCLES` versus one cycle more; an off-by-one there would let a too-soon edge count or drop a genuine cycle. Random bursts of short noise gaps mixed with clean periods test that no noise pattern adds a pulse; a design that counts every edge would run fast. A long flat low after a qualified edge, and a lone rising edge, catch a timer that re-fires or reacts to the wrong edge direction. Mid-run reset and the divide-by-50 build catch a divider that keeps stale counts or uses the wrong second-stage ratio.

// File: rtl/mains_pkg.sv
package mains_pkg;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_RUN  = 2'd1,
        RAMP_FIRE = 2'd2
    } ramp_state_e;

    // Second divider ratio chosen from the nominal line frequency.
    function automatic int second_stage_mod(input int line_hz);
        return (line_hz == 50) ? 5 : 6;
    endfunction

endpackage

// File: rtl/mains_edge_sync.sv
module mains_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/mains_ramp_fsm.sv
module mains_ramp_fsm
    import mains_pkg::*;
#(
    parameter int RAMP_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    output logic qual_o
);
    localparam int RW = $clog2(RAMP_CYCLES + 1);
    localparam logic [RW-1:0] LAST = RW'(RAMP_CYCLES - 1);

    ramp_state_e   state_q, state_d;
    logic [RW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RAMP_HOLD;
            cnt_q   <= LAST;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RAMP_HOLD: begin
                if (fall_i) begin
                    state_d = RAMP_RUN;
                    cnt_d   = '0;
                end
            end
            RAMP_RUN: begin
                if (fall_i) begin
                    state_d = RAMP_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = RAMP_FIRE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RAMP_FIRE: begin
                if (fall_i) begin
                    state_d = RAMP_RUN;
                    cnt_d   = '0;
                end else begin
                    state_d = RAMP_HOLD;
                end
            end
            default: begin
                state_d = RAMP_HOLD;
                cnt_d   = LAST;
            end
        endcase
    end

    // Outputs
    always_comb begin
        qual_o = (state_q == RAMP_FIRE);
    end
endmodule

// File: rtl/mains_mod_counter.sv
module mains_mod_counter #(
    parameter int MOD = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic wrap_o
);
    localparam int CW = (MOD > 1) ? $clog2(MOD) : 1;
    localparam logic [CW-1:0] TOP = CW'(MOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        end
    end

    assign wrap_o = en_i & (cnt_q == TOP);
endmodule

// File: rtl/mains_tick_gen.sv
module mains_tick_gen
    import mains_pkg::*;
#(
    parameter int LINE_HZ     = 60,
    parameter int CLK_HZ      = 1_000_000,
    parameter int RAMP_CYCLES = CLK_HZ / (2 * LINE_HZ),
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic qual_pulse_o,
    output logic tick_o
);
    localparam int DIV_A     = 10;
    localparam int DIV_B     = second_stage_mod(LINE_HZ);
    localparam int TOTAL_DIV = DIV_A * DIV_B;

    logic fall_w;
    logic qual_w;
    logic wrap_a_w;
    logic wrap_b_w;
    logic tick_q;

    mains_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(line_in),
        .fall_o (fall_w)
    );

    mains_ramp_fsm #(.RAMP_CYCLES(RAMP_CYCLES)) u_ramp (
        .clk   (clk),
        .rst   (rst),
        .fall_i(fall_w),
        .qual_o(qual_w)
    );

    mains_mod_counter #(.MOD(DIV_A)) u_div_a (
        .clk   (clk),
        .rst   (rst),
        .en_i  (qual_w),
        .wrap_o(wrap_a_w)
    );

    mains_mod_counter #(.MOD(DIV_B)) u_div_b (
        .clk   (clk),
        .rst   (rst),
        .en_i  (wrap_a_w),
        .wrap_o(wrap_b_w)
    );

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= wrap_b_w;
    end

    assign qual_pulse_o = qual_w;
    assign tick_o       = tick_q;
endmodule

// File: rtl/mains_tick_gen_chk.sv
module mains_tick_gen_chk #(
    parameter int TOTAL_DIV = 60
) (
    input logic clk,
    input logic rst,
    input logic fall_evt,
    input logic qual,
    input logic tick
);
    logic [7:0] qc_q;

    always_ff @(posedge clk) begin
        if (rst)       qc_q <= '0;
        else if (tick) qc_q <= qual ? 8'd1 : 8'd0;
        else if (qual) qc_q <= qc_q + 8'd1;
    end

    // R4
    qual_single_chk: assert property (@(posedge clk) disable iff (rst)
        qual |=> !qual);

    // R3
    fall_cancels_chk: assert property (@(posedge clk) disable iff (rst)
        fall_evt |=> !qual);

    // R9
    tick_follows_qual_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> ($past(qual) && !qual));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!qual && !tick));

    // R6
    tick_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (qc_q == 8'(TOTAL_DIV)));
endmodule

bind mains_tick_gen mains_tick_gen_chk #(.TOTAL_DIV(TOTAL_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fall_evt(fall_w),
    .qual    (qual_pulse_o),
    .tick    (tick_o)
);

// File: tb/mains_tick_gen_tb.sv
`timescale 1ns/1ps
module mains_tick_gen_tb;
    localparam int THR = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_r = 1'b0;
    logic qual60, tick60, qual50, tick50;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int qcnt = 0, tcnt60 = 0, tcnt50 = 0;
    int last_q_cyc = -1;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mains_tick_gen #(.LINE_HZ(60), .RAMP_CYCLES(THR)) u_dut (
        .clk(clk), .rst(rst), .line_in(line_r),
        .qual_pulse_o(qual60), .tick_o(tick60));

    mains_tick_gen #(.LINE_HZ(50), .RAMP_CYCLES(THR)) u_dut50 (
        .clk(clk), .rst(rst), .line_in(line_r),
        .qual_pulse_o(qual50), .tick_o(tick50));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_qualifies(input int lo);
        return (lo + 1) > THR;
    endfunction

    // Monitor, sampled at the falling clock edge
    always @(negedge clk) begin
        if (!rst) begin
            if (qual60) begin qcnt++; last_q_cyc = cyc; end
            if (tick60) begin
                tcnt60++;
                chk("R6 tick one cycle after qual", cyc - last_q_cyc, 1);
            end
            if (tick50) tcnt50++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One high cycle then lo low cycles; fall-to-fall gap is lo+1.
    task automatic period(input int lo);
        line_r = 1'b1;
        cycles(1);
        line_r = 1'b0;
        cycles(lo);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        line_r = 1'b0;
        cycles(3);
        rst = 1'b0;
        cycles(2);
    endtask

    initial begin
        int q0, t0, t50, fall_cyc, expq, lo;
        void'($urandom(32'd1234));
        @(negedge clk);
        chk("R8 qual low in reset", qual60, 0);
        chk("R8 tick low in reset", tick60, 0);
        do_reset();

        // R8 / R1: steady levels after reset give nothing
        q0 = qcnt;
        cycles(3 * THR);
        chk("R8 no pulse without edge", qcnt - q0, 0);
        line_r = 1'b1;
        cycles(3 * THR);
        chk("R1 rising edge ignored", qcnt - q0, 0);
        chk("R1 steady high ignored", qual60, 0);

        // R2 latency and R4 single pulse with no re-fire
        line_r = 1'b0;
        fall_cyc = cyc;
        cycles(6 * THR);
        chk("R4 exactly one pulse", qcnt - q0, 1);
        chk("R2 latency", last_q_cyc - fall_cyc, THR + 3);

        // R3 boundary: gap == THR swallowed, gap == THR+1 qualifies
        q0 = qcnt;
        period(THR - 1);
        period(2 * THR);
        chk("R3 gap equal threshold swallowed", qcnt - q0, 1);
        q0 = qcnt;
        period(THR);
        period(2 * THR);
        chk("R3 gap threshold+1 qualifies", qcnt - q0, 2);

        // R5 noise burst inside one cycle never adds a count
        q0 = qcnt;
        period(3); period(1); period(5);
        period(2 * THR);
        chk("R5 burst gives one pulse", qcnt - q0, 1);

        // R5/R6/R7 random mix from reset
        do_reset();
        q0 = qcnt; t0 = tcnt60; t50 = tcnt50; expq = 0;
        for (int i = 0; i < 420; i++) begin
            if ($urandom_range(0, 9) < 3) lo = $urandom_range(1, THR - 1);
            else lo = $urandom_range(THR - 2, 2 * THR);
            if (exp_qualifies(lo)) expq++;
            period(lo);
        end
        period(2 * THR);
        expq++;
        cycles(4);
        chk("R5 random pulse count", qcnt - q0, expq);
        chk("R6 ticks per 60", tcnt60 - t0, expq / 60);
        chk("R7 ticks per 50", tcnt50 - t50, expq / 50);

        // R8 mid-run reset clears the divider
        do_reset();
        for (int i = 0; i < 30; i++) period(THR + 2);
        do_reset();
        q0 = qcnt; t0 = tcnt60; t50 = tcnt50;
        for (int i = 0; i < 59; i++) period(THR + 2);
        cycles(4);
        chk("R8 divider restarted, no early tick", tcnt60 - t0, 0);
        period(THR + 2);
        cycles(4);
        chk("R8 R6 tick on 60th after reset", tcnt60 - t0, 1);
        chk("R7 tick on 50th after reset", tcnt50 - t50, 1);
        chk("R5 clean pulse count", qcnt - q0, 60);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule